// File: doc/BRIEF.md
# Byte Command Controller for a Coax Word Link

This block sits between a byte-oriented serial slave and the transmit and receive word buffers of a coax link. The serial slave hands over one byte at a time with a one-cycle strobe. An active-low select frames each command. The controller decodes the first byte of each frame as an opcode. What it does with the bytes that follow depends on that opcode.

A transmit command clears the transmit buffer. It then packs each following pair of bytes into one 10-bit word and loads that word into the buffer. Releasing the select starts transmission. A receive command turns each buffered 10-bit word into two response bytes. The first of these bytes also carries an error flag and an empty flag. The controller pops a word from the receive buffer only after it has returned that word. All buffer controls and the response byte come from registers.

Top module: `spi_coax_cmd`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is zero.
- R2: When the opcode byte 0x04 is taken while tx_busy is low, the block gives exactly one tx_clear pulse of one cycle.
- R3: In a transmit command, every pair of bytes after the opcode makes one tx_load pulse. The word is {first byte bits 1:0, second byte bits 7:0}. The upper six bits of the first byte are ignored.
- R4: When cs_n rises during a transmit command, the block gives exactly one tx_start pulse. Receive commands and discarded commands never give tx_start.
- R5: A lone byte at the end of a transmit command, with no partner, loads nothing.
- R6: If tx_busy is high when the 0x04 opcode arrives, the whole command is dropped: no clear, no load and no start. Data bytes that arrive while tx_busy is high are ignored and do not advance the byte pairing.
- R7: After the opcode 0x05, and after each second data byte of a receive command, resp_byte = {rx_err, rx_empty, 4'b0000, rx_word[9:8]}. Bits 1:0 are forced to zero when rx_empty is high.
- R8: The byte after that header makes resp_byte = rx_word[7:0] and gives one rx_pop pulse, provided the header reported not-empty. If the header reported empty, the byte is 0x00 and there is no pop.
- R9: An opcode other than 0x04 or 0x05 makes the block ignore every remaining byte of the frame. resp_byte stays 0x00 and there are no buffer strobes.
- R10: Byte strobes while cs_n is high are ignored. A high cs_n returns resp_byte to 0x00.
- R11: The first byte after cs_n goes low is always decoded as an opcode, whatever the previous frame did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low command frame select |
| byte_stb | input | 1 | One-cycle strobe marking a received byte |
| byte_in | input | 8 | Received byte |
| resp_byte | output | 8 | Byte to return on the next transfer |
| tx_clear | output | 1 | Pulse clearing the transmit buffer |
| tx_word | output | 10 | Word to load into the transmit buffer |
| tx_load | output | 1 | Pulse loading tx_word |
| tx_start | output | 1 | Pulse starting transmission |
| tx_busy | input | 1 | Transmitter is sending |
| rx_word | input | 10 | Word at the head of the receive buffer |
| rx_err | input | 1 | Receive error flag |
| rx_empty | input | 1 | Receive buffer is empty |
| rx_pop | output | 1 | Pulse removing the head receive word |

## Verification
The assertions check properties that hold on every cycle. At most one buffer strobe is high in any cycle. A load always follows a taken byte and carries that byte as its low half. Neither a clear nor a load follows a cycle with tx_busy high. A start only follows a cycle with cs_n high. A pop only follows a byte taken inside a frame. A dropped frame stays dropped until cs_n rises. Some behaviour needs whole frames to show, and only the bench scenarios cover it. This covers the exact count of loads for odd and even byte counts, and the order and content of the packed words. It also covers the header and low-byte pattern across a draining receive buffer, and the fresh opcode decode after a discarded frame.

// File: rtl/spi_coax_pkg.sv
package spi_coax_pkg;
  typedef enum logic [2:0] {
    ST_OPC,
    ST_TXH,
    ST_TXL,
    ST_RXL,
    ST_RXH,
    ST_DROP
  } cmd_state_t;

  typedef struct packed {
    logic clear;
    logic hi;
    logic lo;
    logic start;
    logic head;
    logic tail;
    logic idle;
  } cmd_ev_t;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_coax_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPC_TX = 8'h04,
  parameter logic [BYTE_W-1:0] OPC_RX = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              tx_busy,
  output cmd_ev_t           ev
);
  cmd_state_t state_q, state_d;

  always_comb begin
    ev      = '0;
    state_d = state_q;
    if (cs_n) begin
      state_d  = ST_OPC;
      ev.idle  = 1'b1;
      ev.start = (state_q == ST_TXH) || (state_q == ST_TXL);
    end else if (byte_stb) begin
      case (state_q)
        ST_OPC: begin
          if (byte_in == OPC_TX) begin
            if (tx_busy) state_d = ST_DROP;
            else begin
              ev.clear = 1'b1;
              state_d  = ST_TXH;
            end
          end else if (byte_in == OPC_RX) begin
            ev.head = 1'b1;
            state_d = ST_RXL;
          end else begin
            state_d = ST_DROP;
          end
        end
        ST_TXH: if (!tx_busy) begin
          ev.hi   = 1'b1;
          state_d = ST_TXL;
        end
        ST_TXL: if (!tx_busy) begin
          ev.lo   = 1'b1;
          state_d = ST_TXH;
        end
        ST_RXL: begin
          ev.tail = 1'b1;
          state_d = ST_RXH;
        end
        ST_RXH: begin
          ev.head = 1'b1;
          state_d = ST_RXL;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OPC;
    else     state_q <= state_d;
  end

  // R9: a dropped frame stays dropped while select is held
  a_r9_drop_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DROP && !cs_n) |=> (state_q == ST_DROP))
    else $error("R9 dropped frame resumed decoding");

  // R11: released select always returns to opcode decode
  a_r11_fresh_opcode: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (state_q == ST_OPC))
    else $error("R11 not back at opcode decode");
endmodule

// File: rtl/spi_tx_packer.sv
module spi_tx_packer #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_clear,
  input  logic              ev_hi,
  input  logic              ev_lo,
  input  logic              ev_start,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              tx_clear,
  output logic              tx_load,
  output logic              tx_start,
  output logic [WORD_W-1:0] tx_word
);
  localparam int HI_W = WORD_W - BYTE_W;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      tx_word  <= '0;
      tx_clear <= 1'b0;
      tx_load  <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      tx_clear <= ev_clear;
      tx_load  <= ev_lo;
      tx_start <= ev_start;
      if (ev_hi) hi_q    <= byte_in[HI_W-1:0];
      if (ev_lo) tx_word <= {hi_q, byte_in};
    end
  end

  // R3: a load lasts one cycle because it needs two taken bytes
  a_r3_load_single: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load)
    else $error("R3 back-to-back load");
endmodule

// File: rtl/spi_rx_formatter.sv
module spi_rx_formatter #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_head,
  input  logic              ev_tail,
  input  logic              ev_idle,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_err,
  input  logic              rx_empty,
  output logic [BYTE_W-1:0] resp_byte,
  output logic              rx_pop
);
  localparam int HI_W  = WORD_W - BYTE_W;
  localparam int PAD_W = BYTE_W - 2 - HI_W;

  logic head_empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_byte    <= '0;
      rx_pop       <= 1'b0;
      head_empty_q <= 1'b1;
    end else begin
      rx_pop <= ev_tail && !head_empty_q;
      if (ev_idle) begin
        resp_byte    <= '0;
        head_empty_q <= 1'b1;
      end else if (ev_head) begin
        head_empty_q <= rx_empty;
        resp_byte    <= {rx_err, rx_empty, {PAD_W{1'b0}},
                         rx_empty ? {HI_W{1'b0}} : rx_word[WORD_W-1:BYTE_W]};
      end else if (ev_tail) begin
        resp_byte <= head_empty_q ? '0 : rx_word[BYTE_W-1:0];
      end
    end
  end

  // R8: pops come one at a time, one per header/data pair
  a_r8_pop_single: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop)
    else $error("R8 repeated pop");
endmodule

// File: rtl/spi_coax_cmd.sv
module spi_coax_cmd
  import spi_coax_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 10,
  parameter logic [BYTE_W-1:0] OPC_TX = 8'h04,
  parameter logic [BYTE_W-1:0] OPC_RX = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] resp_byte,
  output logic              tx_clear,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_load,
  output logic              tx_start,
  input  logic              tx_busy,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_err,
  input  logic              rx_empty,
  output logic              rx_pop
);
  cmd_ev_t ev;

  spi_cmd_decode #(.BYTE_W(BYTE_W), .OPC_TX(OPC_TX), .OPC_RX(OPC_RX)) u_decode (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_stb(byte_stb),
    .byte_in(byte_in), .tx_busy(tx_busy), .ev(ev)
  );

  spi_tx_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .ev_clear(ev.clear), .ev_hi(ev.hi), .ev_lo(ev.lo),
    .ev_start(ev.start), .byte_in(byte_in), .tx_clear(tx_clear),
    .tx_load(tx_load), .tx_start(tx_start), .tx_word(tx_word)
  );

  spi_rx_formatter #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_fmt (
    .clk(clk), .rst(rst), .ev_head(ev.head), .ev_tail(ev.tail), .ev_idle(ev.idle),
    .rx_word(rx_word), .rx_err(rx_err), .rx_empty(rx_empty),
    .resp_byte(resp_byte), .rx_pop(rx_pop)
  );

  // R3: a loaded word carries the byte taken in the previous cycle as its low half
  a_r3_load_low_byte: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> ($past(byte_stb) && tx_word[BYTE_W-1:0] == $past(byte_in)))
    else $error("R3 load low half mismatch");

  // R6: clear and load never follow a busy cycle
  a_r6_no_action_busy: assert property (@(posedge clk) disable iff (rst)
    (tx_load || tx_clear) |-> !$past(tx_busy))
    else $error("R6 action while busy");

  // R4: start follows a released select
  a_r4_start_on_release: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(cs_n))
    else $error("R4 start without release");

  // R8: pop follows a byte taken inside a frame
  a_r8_pop_after_byte: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> ($past(byte_stb) && !$past(cs_n)))
    else $error("R8 pop without byte");

  // R10: at most one buffer strobe per cycle
  a_r10_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_clear, tx_load, tx_start, rx_pop}))
    else $error("R10 several strobes at once");
endmodule

// File: tb/test_spi_coax_cmd.sv
module test_spi_coax_cmd;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       byte_stb = 1'b0;
  logic [7:0] byte_in = '0;
  logic [7:0] resp_byte;
  logic       tx_clear, tx_load, tx_start, rx_pop;
  logic [9:0] tx_word;
  logic       tx_busy = 1'b0;
  logic       rx_err = 1'b0;
  logic       rx_empty;
  logic [9:0] rx_word;

  always #5 clk = ~clk;

  spi_coax_cmd i_spi_coax_cmd (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_stb(byte_stb), .byte_in(byte_in),
    .resp_byte(resp_byte), .tx_clear(tx_clear), .tx_word(tx_word),
    .tx_load(tx_load), .tx_start(tx_start), .tx_busy(tx_busy),
    .rx_word(rx_word), .rx_err(rx_err), .rx_empty(rx_empty), .rx_pop(rx_pop)
  );

  int checks = 0;
  int errors = 0;
  int n_clear = 0, n_load = 0, n_start = 0;
  logic [5:0] n_pop = '0;
  logic [5:0] wr = '0;
  logic [5:0] mrd = '0;
  logic [9:0] rxmem [32];
  logic [9:0] cap [64];
  logic [9:0] expw [16];

  assign rx_word  = rxmem[n_pop[4:0]];
  assign rx_empty = (wr == n_pop);

  always @(posedge clk) begin
    if (tx_clear) n_clear <= n_clear + 1;
    if (tx_start) n_start <= n_start + 1;
    if (rx_pop)   n_pop   <= n_pop + 1'b1;
    if (tx_load) begin
      cap[n_load[5:0]] <= tx_word;
      n_load <= n_load + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] head_b(input logic err, input logic emp, input logic [9:0] w);
    return {err, emp, 4'b0000, emp ? 2'b00 : w[9:8]};
  endfunction

  task automatic send(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    byte_in  = b;
    byte_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0;
    r = resp_byte;
    repeat (2) @(negedge clk);
  endtask

  task automatic open_cmd;
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic close_cmd;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_tx(input int pairs, input bit odd, input bit busy_mid);
    int c0, l0, s0;
    logic [7:0] r;
    logic [7:0] fb;
    c0 = n_clear; l0 = n_load; s0 = n_start;
    open_cmd();
    send(8'h04, r);
    for (int i = 0; i < pairs; i++) begin
      expw[i] = 10'($urandom);
      fb = {6'($urandom), expw[i][9:8]};
      send(fb, r);
      if (busy_mid && i == 0) begin
        tx_busy = 1'b1;
        send(8'hFF, r);
        send(8'h3C, r);
        tx_busy = 1'b0;
      end
      send(expw[i][7:0], r);
    end
    if (odd) send(8'($urandom), r);
    close_cmd();
    chk(n_clear - c0 == 1, "R2 clear count", n_clear - c0, 1);
    chk(n_load - l0 == pairs, odd ? "R5 load count" : "R3 load count", n_load - l0, pairs);
    for (int i = 0; i < pairs; i++)
      chk(cap[6'(l0 + i)] == expw[i], busy_mid ? "R6 word after busy" : "R3 word",
          cap[6'(l0 + i)], expw[i]);
    chk(n_start - s0 == 1, "R4 start count", n_start - s0, 1);
  endtask

  task automatic push_rx(input int k);
    for (int i = 0; i < k; i++) begin
      rxmem[wr[4:0]] = 10'($urandom);
      wr = wr + 1'b1;
    end
  endtask

  task automatic run_rx(input int words);
    logic [7:0] r;
    logic emp;
    int s0;
    logic [5:0] p0;
    s0 = n_start; p0 = n_pop;
    open_cmd();
    emp = (wr == mrd);
    send(8'h05, r);
    chk(r == head_b(rx_err, emp, rxmem[mrd[4:0]]), "R7 first header", r,
        head_b(rx_err, emp, rxmem[mrd[4:0]]));
    for (int i = 0; i < words; i++) begin
      send(8'h00, r);
      chk(r == (emp ? 8'h00 : rxmem[mrd[4:0]][7:0]), "R8 low byte", r,
          emp ? 8'h00 : rxmem[mrd[4:0]][7:0]);
      if (!emp) mrd = mrd + 1'b1;
      emp = (wr == mrd);
      send(8'h00, r);
      chk(r == head_b(rx_err, emp, rxmem[mrd[4:0]]), "R7 next header", r,
          head_b(rx_err, emp, rxmem[mrd[4:0]]));
    end
    close_cmd();
    chk(n_pop == mrd, "R8 pop count", n_pop - p0, mrd - p0);
    chk(n_start == s0, "R4 no start after receive", n_start - s0, 0);
    chk(resp_byte == 8'h00, "R10 response cleared", resp_byte, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int c0, l0, s0;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk({resp_byte, tx_clear, tx_load, tx_start, rx_pop, tx_word} == '0, "R1 in reset",
        {resp_byte, tx_clear, tx_load, tx_start, rx_pop, tx_word}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({resp_byte, tx_clear, tx_load, tx_start, rx_pop, tx_word} == '0, "R1 after reset",
        {resp_byte, tx_clear, tx_load, tx_start, rx_pop, tx_word}, 0);

    // directed transmit cases
    run_tx(3, 1'b0, 1'b0);
    run_tx(2, 1'b1, 1'b0);
    run_tx(2, 1'b0, 1'b1);
    run_tx(0, 1'b0, 1'b0);

    // R6: opcode while busy drops the frame
    c0 = n_clear; l0 = n_load; s0 = n_start;
    tx_busy = 1'b1;
    open_cmd();
    send(8'h04, r);
    tx_busy = 1'b0;
    send(8'h03, r);
    send(8'hA5, r);
    close_cmd();
    chk(n_clear == c0 && n_load == l0 && n_start == s0, "R6 busy opcode dropped",
        (n_clear - c0) + (n_load - l0) + (n_start - s0), 0);

    // R9: unknown opcode, then tx/rx opcode bytes inside the frame
    c0 = n_clear; l0 = n_load; s0 = n_start;
    push_rx(1);
    open_cmd();
    send(8'h33, r);
    send(8'h05, r);
    chk(r == 8'h00, "R9 response stays zero", r, 0);
    send(8'h04, r);
    send(8'h01, r);
    send(8'h02, r);
    close_cmd();
    chk(n_clear == c0 && n_load == l0 && n_start == s0 && n_pop == mrd,
        "R9 no strobes", (n_clear - c0) + (n_load - l0) + (n_start - s0), 0);

    // R10: strobes with select high
    c0 = n_clear; l0 = n_load;
    send(8'h04, r);
    send(8'h01, r);
    send(8'h02, r);
    chk(n_clear == c0 && n_load == l0 && r == 8'h00, "R10 idle strobes ignored",
        (n_clear - c0) + (n_load - l0), 0);

    // R11: after the discarded frame a new frame decodes its opcode
    run_tx(1, 1'b0, 1'b0);

    // receive: pending word, then drain past empty
    rx_err = 1'b1;
    run_rx(2);
    rx_err = 1'b0;
    run_rx(1);
    push_rx(3);
    run_rx(1);
    run_rx(3);

    // random mix
    for (int it = 0; it < 24; it++) begin
      if ($urandom_range(1, 0) == 1) begin
        run_tx(int'($urandom_range(5, 1)), 1'($urandom), 1'b0);
      end else begin
        rx_err = 1'($urandom);
        if ((wr - mrd) < 6'd20) push_rx(int'($urandom_range(4, 0)));
        run_rx(int'($urandom_range(5, 0)));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule